// File: doc/BRIEF.md
# Operand-Split Mixed-Architecture Multiplier

This block multiplies two unsigned 8-bit operands and returns the 16-bit product one clock after the operands are presented with a valid flag. Internally each operand is cut into a high and a low 4-bit half, giving four 4×4 cross products. Each cross product has its own small multiplier. Two of these are tree reducers: an AND plane, carry-save compression layers built from full and half adders, and a closing carry-propagate adder. The other two are array multipliers whose rows are skipped whenever the matching control bit is zero.

A parameter picks which half of the second operand drives the row-skipping units. The default hands the low half of `y` to the skipping units, so `x_hi·y_lo` and `x_lo·y_lo` go through arrays, and `x_hi·y_hi` and `x_lo·y_hi` go through trees. The four cross products are weighted by 2^8, 2^4, 2^4 and 2^0 and added in one combinational stage. The sum is then captured in the output register.

Top module: `mixmul_split`

## Requirements
- R1: One cycle after a rising clock edge that samples `in_valid` high, `p` equals the unsigned product `x*y` of the operands sampled at that edge, for every one of the 65,536 operand pairs.
- R2: `out_valid` equals `in_valid` as sampled at the previous rising clock edge.
- R3: While `rst_n` is low, `out_valid` is 0 and `p` is 0. A low level on `rst_n` clears both at once, without waiting for a clock edge.
- R4: At an edge where `in_valid` is low, `p` keeps its previous value, whatever `x` and `y` carry.
- R5: A row-skipping sub-multiplier whose control half is zero produces a zero cross product. Its output equals the exact 4×4 product for every input.
- R6: Each tree sub-multiplier produces the exact 4×4 product of its two halves.
- R7: Cross products are weighted as follows: `x[7:4]·y[7:4]` by 256, `x[7:4]·y[3:0]` and `x[3:0]·y[7:4]` by 16, and `x[3:0]·y[3:0]` by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| in_valid | input | 1 | Marks `x` and `y` as a valid operand pair at this edge |
| x | input | 8 | First unsigned operand |
| y | input | 8 | Second unsigned operand; one half of it controls row skipping |
| out_valid | output | 1 | High when `p` holds a new product |
| p | output | 16 | Registered unsigned product |

## Verification
Every product and valid flag is due exactly one rising edge after the operands are sampled. Because of that, the bench drives each operand pair at a falling edge and compares both outputs at the very next falling edge, against a model that updates only when the driven valid was high. All operand pairs are streamed back to back, which covers R1, R5 and R6 across the whole input space. Directed pairs isolate each weight of R7. Seeded random traffic with idle gaps checks that `p` stays put at the next falling edge after an idle cycle. An asynchronous reset applied in mid-stream is checked before any further clock edge arrives.

// File: rtl/mixmul_pkg.sv
package mixmul_pkg;

  // Which half of the second operand controls the row-skipping units.
  typedef enum logic [0:0] {
    BYP_Y_LOW  = 1'b0,
    BYP_Y_HIGH = 1'b1
  } byp_sel_e;

  // Rows left after one layer of 3:2 compression on n rows.
  function automatic int unsigned rows_after_layer(input int unsigned n);
    return n - (n / 3);
  endfunction

endpackage

// File: rtl/mm_wallace.sv
module mm_wallace #(
  parameter int W = 4
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);
  localparam int PW   = 2 * W;
  localparam int NL   = W;       // enough layers to reach two rows
  localparam int SLOT = 3 * W;   // row slots per layer, slack for indexing

  logic [PW-1:0] lvl [0:NL][0:SLOT-1];
  logic [PW-1:0] row_sum;
  logic [PW-1:0] row_cry;

  always_comb begin
    int unsigned cnt;
    int unsigned grp;
    int unsigned rest;
    for (int l = 0; l <= NL; l++) begin
      for (int i = 0; i < SLOT; i++) begin
        lvl[l][i] = '0;
      end
    end
    // AND plane: one shifted row per bit of b
    for (int i = 0; i < W; i++) begin
      lvl[0][i] = PW'({W{b[i]}} & a) << i;
    end
    cnt = W;
    // compression layers: each group of three rows becomes sum and carry rows
    for (int l = 0; l < NL; l++) begin
      grp  = cnt / 3;
      rest = cnt - 3 * grp;
      for (int g = 0; g < W; g++) begin
        if (g < int'(grp)) begin
          lvl[l+1][2*g]   = lvl[l][3*g] ^ lvl[l][3*g+1] ^ lvl[l][3*g+2];
          lvl[l+1][2*g+1] = ((lvl[l][3*g] & lvl[l][3*g+1]) |
                             (lvl[l][3*g] & lvl[l][3*g+2]) |
                             (lvl[l][3*g+1] & lvl[l][3*g+2])) << 1;
        end
      end
      for (int r = 0; r < W; r++) begin
        if (r < int'(rest)) begin
          lvl[l+1][2*grp+r] = lvl[l][3*grp+r];
        end
      end
      cnt = mixmul_pkg::rows_after_layer(cnt);
    end
  end

  assign row_sum = lvl[NL][0];
  assign row_cry = lvl[NL][1];

  // closing carry-propagate adder
  assign prod = row_sum + row_cry;

  always_comb begin
    a_r6_tree_exact: assert (prod == PW'(a) * PW'(b))
      else $error("tree product mismatch");
  end

endmodule

// File: rtl/mm_bypass.sv
module mm_bypass #(
  parameter int W = 4
) (
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   ctrl,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  logic [W:0][PW-1:0] acc_s;
  logic [W:0][PW-1:0] acc_c;

  assign acc_s[0] = '0;
  assign acc_c[0] = '0;

  // one carry-save row per control bit; a zero bit passes the row through untouched
  for (genvar j = 0; j < W; j++) begin : g_row
    logic [PW-1:0] pp_row;
    logic [PW-1:0] s_new;
    logic [PW-1:0] c_new;
    assign pp_row = PW'(mcand) << j;
    assign s_new  = acc_s[j] ^ acc_c[j] ^ pp_row;
    assign c_new  = ((acc_s[j] & acc_c[j]) | (acc_s[j] & pp_row) |
                     (acc_c[j] & pp_row)) << 1;
    assign acc_s[j+1] = ctrl[j] ? s_new : acc_s[j];
    assign acc_c[j+1] = ctrl[j] ? c_new : acc_c[j];
  end

  assign prod = acc_s[W] + acc_c[W];

  always_comb begin
    if (ctrl == '0) begin
      a_r5_idle_zero: assert (prod == '0)
        else $error("skipped array gave nonzero product");
    end
    a_r5_array_exact: assert (prod == PW'(mcand) * PW'(ctrl))
      else $error("array product mismatch");
  end

endmodule

// File: rtl/mm_recombine.sv
module mm_recombine #(
  parameter int W = 4
) (
  input  logic [2*W-1:0] pp_hh,
  input  logic [2*W-1:0] pp_hl,
  input  logic [2*W-1:0] pp_lh,
  input  logic [2*W-1:0] pp_ll,
  output logic [4*W-1:0] sum
);
  localparam int RW = 4 * W;

  logic [RW-1:0] mid;

  assign mid = RW'(pp_hl) + RW'(pp_lh);
  assign sum = (RW'(pp_hh) << (2 * W)) + (mid << W) + RW'(pp_ll);

endmodule

// File: rtl/mixmul_split.sv
module mixmul_split #(
  parameter int                   HALF_W  = 4,
  parameter mixmul_pkg::byp_sel_e BYP_SEL = mixmul_pkg::BYP_Y_LOW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [2*HALF_W-1:0]   x,
  input  logic [2*HALF_W-1:0]   y,
  output logic                  out_valid,
  output logic [4*HALF_W-1:0]   p
);
  localparam int OPW = 2 * HALF_W;
  localparam int PPW = 2 * HALF_W;
  localparam int RW  = 4 * HALF_W;
  localparam int BYP_Y_HALF = (BYP_SEL == mixmul_pkg::BYP_Y_HIGH) ? 1 : 0;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // cross products; index = {x half, y half}, 1 selects the high half
  logic [3:0][PPW-1:0] pp;

  for (genvar k = 0; k < 4; k++) begin : g_xp
    localparam int XH = k / 2;
    localparam int YH = k % 2;
    logic [HALF_W-1:0] xs;
    logic [HALF_W-1:0] ys;
    assign xs = (XH == 1) ? x[OPW-1:HALF_W] : x[HALF_W-1:0];
    assign ys = (YH == 1) ? y[OPW-1:HALF_W] : y[HALF_W-1:0];
    if (YH == BYP_Y_HALF) begin : g_arr
      mm_bypass #(.W(HALF_W)) u_arr (
        .mcand (xs),
        .ctrl  (ys),
        .prod  (pp[k])
      );
    end else begin : g_tree
      mm_wallace #(.W(HALF_W)) u_tree (
        .a    (xs),
        .b    (ys),
        .prod (pp[k])
      );
    end
  end

  logic [RW-1:0] sum_c;

  mm_recombine #(.W(HALF_W)) u_sum (
    .pp_hh (pp[3]),
    .pp_hl (pp[2]),
    .pp_lh (pp[1]),
    .pp_ll (pp[0]),
    .sum   (sum_c)
  );

  // output stage: next-state and register kept apart
  logic [RW-1:0] p_d;
  logic [RW-1:0] p_q;
  logic          v_d;
  logic          v_q;

  always_comb begin
    v_d = in_valid;
    p_d = p_q;
    if (in_valid) begin
      p_d = sum_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      p_q <= '0;
    end else if (!rst_sync_n) begin
      v_q <= 1'b0;
      p_q <= '0;
    end else begin
      v_q <= v_d;
      p_q <= p_d;
    end
  end

  assign out_valid = v_q;
  assign p         = p_q;

  a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid)
    else $error("out_valid missing after in_valid");

  a_r2_valid_fall: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid)
    else $error("out_valid without in_valid");

  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> $stable(p))
    else $error("p changed on idle cycle");

  a_r1_product: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> (p == RW'($past(x)) * RW'($past(y))))
    else $error("product mismatch");

  a_r3_reset_clear: assert property (@(posedge clk)
    !rst_sync_n |-> (!out_valid && p == '0))
    else $error("outputs not cleared in reset");

endmodule

// File: tb/tb_mixmul_split.sv
module tb_mixmul_split;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  x;
  logic [7:0]  y;
  logic        out_valid;
  logic [15:0] p;

  int n_tests;
  int n_fail;
  int cyc;

  logic [15:0] model_p;
  logic        model_v;

  mixmul_split dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .x         (x),
    .y         (y),
    .out_valid (out_valid),
    .p         (p)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    return 16'(a) * 16'(b);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic apply(input bit v, input logic [7:0] a, input logic [7:0] b,
                       input string req);
    in_valid = v;
    x = a;
    y = b;
    @(negedge clk);
    model_v = v;
    if (v) model_p = ref_mul(a, b);
    chk(out_valid == model_v, {req, " valid"}, 16'(out_valid), 16'(model_v));
    chk(p == model_p, req, p, model_p);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // watchdog
  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<=150000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd5101));
    n_tests  = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    x        = 8'hA5;
    y        = 8'h5A;
    model_p  = '0;
    model_v  = 1'b0;
    repeat (3) @(negedge clk);
    // R3: reset state
    chk(out_valid == 1'b0, "R3 valid in reset", 16'(out_valid), 16'd0);
    chk(p == 16'd0, "R3 p in reset", p, 16'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(p == 16'd0, "R3 p after release", p, 16'd0);

    // directed corners
    apply(1'b1, 8'h00, 8'h00, "R1 zero");
    apply(1'b1, 8'hFF, 8'hFF, "R1 max");
    apply(1'b1, 8'hF0, 8'hF0, "R7 hi*hi weight 256");
    apply(1'b1, 8'hF0, 8'h0F, "R7 xhi*ylo weight 16");
    apply(1'b1, 8'h0F, 8'hF0, "R7 xlo*yhi weight 16");
    apply(1'b1, 8'h0F, 8'h0F, "R7 lo*lo weight 1");
    apply(1'b1, 8'h10, 8'h10, "R7 single bits");
    apply(1'b1, 8'hB7, 8'h30, "R5 array control zero");
    apply(1'b1, 8'h6D, 8'h09, "R6 tree control zero");
    apply(1'b0, 8'h12, 8'h34, "R4 idle hold");
    apply(1'b0, 8'hFF, 8'hFF, "R4 idle hold again");
    apply(1'b1, 8'h80, 8'h81, "R2 valid after idle");

    // exhaustive stream: R1 R5 R6
    for (int i = 0; i < 65536; i++) begin
      apply(1'b1, i[15:8], i[7:0], "R1 exhaustive");
    end

    // seeded random with gaps
    for (int i = 0; i < 3000; i++) begin
      logic       v;
      logic [7:0] a;
      logic [7:0] b;
      v = ($urandom % 3) != 0;
      a = 8'($urandom);
      b = 8'($urandom);
      if (v) apply(1'b1, a, b, "R1 random");
      else   apply(1'b0, a, b, "R4 random idle");
    end

    // R3: asynchronous clear mid-stream
    apply(1'b1, 8'hC3, 8'h3C, "R1 before reset");
    #2;
    rst_n = 1'b0;
    #1;
    chk(p == 16'd0, "R3 async clear p", p, 16'd0);
    chk(out_valid == 1'b0, "R3 async clear valid", 16'(out_valid), 16'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_p = '0;
    model_v = 1'b0;
    apply(1'b1, 8'hE1, 8'h1E, "R2 after reset");

    finish_run();
  end

endmodule